// File: doc/BRIEF.md
# Multi-format I2S serial transmitter

This block turns a stream of stereo PCM sample pairs into a serial audio link made of a bit clock, a word-select (left/right) clock and one data line. Each stereo pair occupies one word-select period, split into a left half (word select low) and a right half (word select high), each half being a fixed number of bit-clock periods long. Data bits change on the falling bit-clock edge so that a receiver can capture them on the rising edge. Bits of a half-frame not covered by the sample are sent as zero.

The block runs either as link master, where it divides its system clock down to produce the bit clock and derives the word-select clock from a bit counter, or as link slave, where both clocks come in from the far end. The slave inputs are oversampled in the system clock domain, and a change of the word-select level marks the half-frame boundary. A run-time format select moves the sample's MSB relative to the word-select edge. In standard mode it comes one bit after the edge, in left-justified mode on the edge itself, and in right-justified mode exactly sample-width bits before the following edge.

Samples arrive through a valid/ready handshake into a one-pair holding register and are taken up at the start of each left half. If nothing is waiting at that moment, the previous pair is sent again and an underrun indication is raised for that frame.

Top module: `i2s_fmt_tx`

## Requirements
- R1: In master mode `bclk_o` is high out of reset, toggles every BCLK_DIV_HALF system clocks (rising edges 2*BCLK_DIV_HALF clocks apart), and `lrc_o` changes only together with a falling `bclk_o` edge, once every HALF_BITS bit periods.
- R2: In master mode `sd_o` changes only in the clock cycle in which `bclk_o` falls.
- R3: With `fmt_sel` 0 (standard; code 3 behaves the same) the MSB of the channel's sample is in bit slot 1 of its half-frame, slot 0 being the first bit period after the word-select change, followed by the lower bits one slot each.
- R4: With `fmt_sel` 1 (left-justified) the MSB is in slot 0, the period that starts with the word-select change.
- R5: With `fmt_sel` 2 (right-justified) the MSB is in slot HALF_BITS-SAMPLE_W, so the LSB is in the last slot before the next word-select change.
- R6: Every slot outside the sample's window carries a zero.
- R7: In slave mode the block follows `bclk_i` and `lrc_i`: data changes after each falling `bclk_i`, and a change of `lrc_i` restarts the slot count at 0, whatever the half-frame length.
- R8: `in_ready` is high exactly while the holding register is empty; a pair accepted with `in_valid` and `in_ready` both high fills it, and it is emptied into the active pair at the next left-half start.
- R9: At a left-half start with the holding register empty the previous pair is repeated and `underrun` is 1 for that frame; `underrun` changes only at left-half starts and returns to 0 at the first left-half start that finds a pair waiting.
- R10: Synchronous active-low reset leaves `sd_o` 0, `in_ready` 1, `underrun` 0, the active pair zero, and in master mode `bclk_o` and `lrc_o` at 1.
- R11: In slave mode `bclk_o` and `lrc_o` are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; in master mode the bit clock is divided from it |
| rst_n | input | 1 | Synchronous active-low reset |
| role_master | input | 1 | 1: generate the link clocks; 0: follow `bclk_i`/`lrc_i` (change only under reset) |
| fmt_sel | input | 2 | Alignment: 0 standard, 1 left-justified, 2 right-justified, 3 as 0 |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | Holding register empty, pair will be taken |
| in_left | input | SAMPLE_W | Left channel sample, MSB first on the line |
| in_right | input | SAMPLE_W | Right channel sample, MSB first on the line |
| bclk_i | input | 1 | Bit clock from the far end (slave mode) |
| lrc_i | input | 1 | Word-select clock from the far end (slave mode), 0 = left |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrc_o | output | 1 | Generated word-select clock (master mode), 0 = left |
| sd_o | output | 1 | Serial data |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
The hardest situation to reach is the underrun frame: the holding register must be empty at the exact bit-clock edge that opens a left half, after a pair has already been sent, so that a repeat is visible rather than zeros. The bench feeds pairs only a few cycles after it has itself seen a left-half start, deliberately skips one frame, and then checks that the repeated bits and the `underrun` level follow. The same schedule runs in every format, in master mode and in slave mode, and one slave run uses a shortened half-frame so that slot restarts are driven by the word-select change and not by a bit count.

// File: rtl/sstx_pkg.sv
// Shared definitions for the serial audio transmitter.
// Assumes: fmt_sel code 3 is decoded as the standard format.
package sstx_pkg;

    typedef enum logic [1:0] {
        FMT_STD   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_ALT   = 2'd3
    } fmt_e;

endpackage

// File: rtl/sstx_bclk_gen.sv
// Master bit-clock divider.
// Toggles bclk every DIV_HALF system clocks while enabled and gives a
// one-cycle strobe in the cycle whose edge drives bclk low.
// Assumes: en changes only while the block is held in reset.
module sstx_bclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bclk,
    output logic fall_stb
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] TERM = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    // Half-period counter and bit-clock toggle; idle high when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            bclk <= 1'b1;
        end else if (cnt == TERM) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobe marks the edge on which bclk goes from high to low.
    assign fall_stb = en && (cnt == TERM) && bclk;

endmodule

// File: rtl/sstx_edge_sync.sv
// Slave-side input conditioning.
// Brings bclk_i and lrc_i into the system clock domain through two flops
// each and flags a falling bit-clock edge for one cycle.
// Assumes: system clock at least about 8x the bit clock, and lrc_i changes
// together with a falling bclk_i edge so both pass the synchronizer alike.
module sstx_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic lrc_in,
    output logic fall_stb,
    output logic lrc_s
);
    logic bclk_meta, bclk_s, bclk_d;
    logic lrc_meta;

    // Two-stage synchronizers plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_meta <= 1'b0;
            bclk_s    <= 1'b0;
            bclk_d    <= 1'b0;
            lrc_meta  <= 1'b1;
            lrc_s     <= 1'b1;
        end else begin
            bclk_meta <= bclk_in;
            bclk_s    <= bclk_meta;
            bclk_d    <= bclk_s;
            lrc_meta  <= lrc_in;
            lrc_s     <= lrc_meta;
        end
    end

    // High for one cycle after a synchronized high-to-low bit-clock step.
    assign fall_stb = bclk_d & ~bclk_s;

endmodule

// File: rtl/sstx_framer.sv
// Slot tracking, sample holding and bit selection.
// On each bit strobe it advances the slot count, tracks the word-select
// level (generating it in master mode, following it in slave mode) and
// registers the next serial bit. A one-pair holding register feeds the
// active pair at each left-half start; an empty holder repeats the pair.
// Assumes: 2 <= W < HALF_BITS, so no format spills into the next half.
module sstx_framer
    import sstx_pkg::*;
#(
    parameter int W         = 16,
    parameter int HALF_BITS = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         master,
    input  logic         lrc_ext,
    input  logic [1:0]   fmt_sel,
    input  logic         in_valid,
    input  logic [W-1:0] in_left,
    input  logic [W-1:0] in_right,
    output logic         in_ready,
    output logic         sd,
    output logic         lrc,
    output logic         underrun
);
    localparam int SLOT_CW = $clog2(HALF_BITS);
    localparam int POS_W   = $clog2(W);
    localparam int RJ_OFF  = HALF_BITS - W;
    localparam logic [SLOT_CW-1:0] SLOT_LAST = SLOT_CW'(HALF_BITS - 1);

    logic [SLOT_CW-1:0] slot_q, slot_nx;
    logic               lrc_q, lrc_nx, lrc_edge;
    logic [W-1:0]       act_l, act_r, hold_l, hold_r;
    logic [W-1:0]       nx_l, nx_r, cur;
    logic               hold_full, accept, frame_start, load;
    logic               sd_q, under_q, bit_nx;
    int                 off, idx;
    logic [POS_W-1:0]   pos;

    // Next word-select level: counted in master mode, followed in slave mode.
    always_comb begin
        if (master) lrc_nx = lrc_q ^ (slot_q == SLOT_LAST);
        else        lrc_nx = lrc_ext;
        lrc_edge = (lrc_nx != lrc_q);
        if (lrc_edge)                slot_nx = '0;
        else if (slot_q != SLOT_LAST) slot_nx = slot_q + 1'b1;
        else                         slot_nx = slot_q;
    end

    // Frame-start and holder transfer decisions.
    assign frame_start = stb && lrc_q && !lrc_nx;
    assign load        = frame_start && hold_full;
    assign accept      = in_valid && !hold_full;
    assign in_ready    = !hold_full;

    // Pair and channel in force for the coming bit period.
    assign nx_l = load ? hold_l : act_l;
    assign nx_r = load ? hold_r : act_r;
    assign cur  = lrc_nx ? nx_r : nx_l;

    // MSB slot for the selected alignment.
    always_comb begin
        case (fmt_e'(fmt_sel))
            FMT_LEFT:  off = 0;
            FMT_RIGHT: off = RJ_OFF;
            default:   off = 1;
        endcase
    end

    // Bit for the coming slot: sample bit inside the window, zero outside.
    always_comb begin
        idx    = int'(slot_nx) - off;
        pos    = '0;
        bit_nx = 1'b0;
        if (idx >= 0 && idx < W) begin
            pos    = POS_W'(W - 1 - idx);
            bit_nx = cur[pos];
        end
    end

    // Slot, word-select, data and underrun state, advanced per bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= SLOT_LAST;
            lrc_q   <= 1'b1;
            sd_q    <= 1'b0;
            under_q <= 1'b0;
            act_l   <= '0;
            act_r   <= '0;
        end else if (stb) begin
            slot_q <= slot_nx;
            lrc_q  <= lrc_nx;
            sd_q   <= bit_nx;
            if (frame_start) under_q <= !hold_full;
            if (load) begin
                act_l <= hold_l;
                act_r <= hold_r;
            end
        end
    end

    // One-pair holding register behind the valid/ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_l    <= '0;
            hold_r    <= '0;
        end else if (accept) begin
            hold_full <= 1'b1;
            hold_l    <= in_left;
            hold_r    <= in_right;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    assign sd       = sd_q;
    assign lrc      = lrc_q;
    assign underrun = under_q;

    // R8: a full holder stays full until a left-half start drains it.
    p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !frame_start) |=> !in_ready);

    // R8: an accepted pair blocks the next offer.
    p_take_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R9: the underrun indication moves only at left-half starts.
    p_under_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(underrun));

endmodule

// File: rtl/i2s_fmt_tx.sv
// Multi-format stereo serial audio transmitter, top level.
// Selects the bit strobe from the internal divider (master) or from the
// synchronized link inputs (slave) and drives the link outputs.
// Assumes: role_master changes only under reset.
module i2s_fmt_tx #(
    parameter int SAMPLE_W      = 16,
    parameter int HALF_BITS     = 32,
    parameter int BCLK_DIV_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                role_master,
    input  logic [1:0]          fmt_sel,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                bclk_i,
    input  logic                lrc_i,
    output logic                bclk_o,
    output logic                lrc_o,
    output logic                sd_o,
    output logic                underrun
);
    logic gen_bclk, gen_fall, sync_fall, sync_lrc, bit_stb, lrc_int;

    sstx_bclk_gen #(.DIV_HALF(BCLK_DIV_HALF)) u_bclk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (role_master),
        .bclk     (gen_bclk),
        .fall_stb (gen_fall)
    );

    sstx_edge_sync u_edge_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_in  (bclk_i),
        .lrc_in   (lrc_i),
        .fall_stb (sync_fall),
        .lrc_s    (sync_lrc)
    );

    // Bit strobe source follows the link role.
    assign bit_stb = role_master ? gen_fall : sync_fall;

    sstx_framer #(.W(SAMPLE_W), .HALF_BITS(HALF_BITS)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (bit_stb),
        .master   (role_master),
        .lrc_ext  (sync_lrc),
        .fmt_sel  (fmt_sel),
        .in_valid (in_valid),
        .in_left  (in_left),
        .in_right (in_right),
        .in_ready (in_ready),
        .sd       (sd_o),
        .lrc      (lrc_int),
        .underrun (underrun)
    );

    // Link clock outputs are driven only in master mode.
    assign bclk_o = role_master & gen_bclk;
    assign lrc_o  = role_master & lrc_int;

    // R2: serial data moves only with a falling generated bit clock.
    p_sd_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (role_master && !$fell(bclk_o)) |-> $stable(sd_o));

    // R1: word select moves only with a falling generated bit clock.
    p_lrc_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (role_master && !$stable(lrc_o)) |-> $fell(bclk_o));

endmodule

// File: tb/i2s_fmt_tx_tb.sv
`timescale 1ns/1ps
module i2s_fmt_tx_tb;
    localparam int W    = 16;
    localparam int HB   = 32;
    localparam int DIVH = 2;
    localparam int HS   = 6;   // slave bit-clock half period in system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic role = 1'b1;
    logic [1:0] fmt = 2'd0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_left = '0, in_right = '0;
    logic bclk_i = 1'b1, lrc_i = 1'b1;
    logic in_ready, bclk_o, lrc_o, sd_o, underrun;

    always #2 clk = ~clk;

    i2s_fmt_tx #(.SAMPLE_W(W), .HALF_BITS(HB), .BCLK_DIV_HALF(DIVH)) u_dut (
        .clk(clk), .rst_n(rst_n), .role_master(role), .fmt_sel(fmt),
        .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
        .in_right(in_right), .bclk_i(bclk_i), .lrc_i(lrc_i),
        .bclk_o(bclk_o), .lrc_o(lrc_o), .sd_o(sd_o), .underrun(underrun)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int left_cnt, m_slot, m_last;
    bit mon_en = 0, m_prev, m_lrc, m_seen, m_sd, p_flag, exp_u;
    bit gen_stop, gen_done;
    logic [W-1:0] cur_l, cur_r, p_l, p_r;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] mk(input int k, input int ch);
        int v;
        v = k * 37831 + ch * 21011 + 12345;
        v = v ^ (v >>> 5);
        mk = W'(v);
        if (k % 2 == 1) mk[W-1] = 1'b1;
        else            mk[0]   = 1'b1;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Line monitor: recovers slots and checks each bit against the formula.
    always @(negedge clk) begin
        bit bck, lv, fell_now, e;
        int off, i;
        string tag;
        logic [W-1:0] smp;
        if (mon_en) begin
            bck = role ? bclk_o : bclk_i;
            lv  = role ? lrc_o  : lrc_i;
            fell_now = m_prev && !bck;
            if (role && sd_o != m_sd)
                chk(fell_now, "R2 sd moved without falling bclk", 0, 1);
            if (bck && !m_prev) begin
                if (role) begin
                    if (m_last >= 0)
                        chk(cyc - m_last == 2 * DIVH, "R1 bclk period", cyc - m_last, 2 * DIVH);
                    m_last = cyc;
                end else begin
                    chk(bclk_o == 0 && lrc_o == 0, "R11 outputs quiet in slave", {bclk_o, lrc_o}, 0);
                end
                if (lv != m_lrc) begin
                    if (role && m_seen)
                        chk(m_slot == HB - 1, "R1 half-frame length", m_slot + 1, HB);
                    m_seen = 1;
                    m_slot = 0;
                    if (!lv) begin
                        if (p_flag) begin
                            cur_l = p_l; cur_r = p_r; p_flag = 0; exp_u = 0;
                        end else begin
                            exp_u = 1;
                        end
                        chk(underrun == exp_u, "R9 underrun at left start", underrun, exp_u);
                        left_cnt = left_cnt + 1;
                    end
                end else if (m_slot != HB - 1) begin
                    m_slot = m_slot + 1;
                end
                m_lrc = lv;
                off = (fmt == 2'd1) ? 0 : (fmt == 2'd2) ? HB - W : 1;
                i   = m_slot - off;
                smp = lv ? cur_r : cur_l;
                if (i >= 0 && i < W) begin
                    e = smp[W - 1 - i];
                    tag = (fmt == 2'd1) ? "R4 left-justified bit" :
                          (fmt == 2'd2) ? "R5 right-justified bit" : "R3 standard bit";
                end else begin
                    e = 1'b0;
                    tag = "R6 zero outside window";
                end
                if (!role) tag = {"R7 slave ", tag};
                chk(sd_o == e, tag, sd_o, e);
            end
            m_prev = bck;
            m_sd   = sd_o;
        end
    end

    task automatic gen_slave(input int hl);
        while (!gen_stop) begin
            for (int h = 0; h < 2; h++) begin
                for (int b = 0; b < hl; b++) begin
                    bclk_i = 1'b0;
                    if (b == 0) lrc_i = h[0];
                    repeat (HS) @(posedge clk);
                    #1;
                    bclk_i = 1'b1;
                    repeat (HS) @(posedge clk);
                    #1;
                end
            end
        end
        gen_done = 1;
    endtask

    task automatic push(input int k);
        @(posedge clk); #1;
        in_valid = 1'b1; in_left = mk(k, 0); in_right = mk(k, 1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        p_l = mk(k, 0); p_r = mk(k, 1); p_flag = 1;
        @(negedge clk);
        chk(in_ready == 0, "R8 ready drops after accept", in_ready, 0);
    endtask

    task automatic run(input bit mst, input logic [1:0] f, input int hl);
        mon_en = 0; rst_n = 0; role = mst; fmt = f; in_valid = 0;
        bclk_i = 1'b1; lrc_i = 1'b1; gen_stop = 0; gen_done = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sd_o == 0, "R10 reset sd", sd_o, 0);
        chk(in_ready == 1, "R10 reset ready", in_ready, 1);
        chk(underrun == 0, "R10 reset underrun", underrun, 0);
        chk(bclk_o == mst, mst ? "R10 reset bclk" : "R11 slave bclk_o", bclk_o, mst);
        chk(lrc_o == mst, mst ? "R10 reset lrc" : "R11 slave lrc_o", lrc_o, mst);
        m_prev = 1; m_lrc = 1; m_slot = HB - 1; m_seen = 0; m_last = -1; m_sd = 0;
        cur_l = '0; cur_r = '0; p_flag = 0; exp_u = 0; left_cnt = 0;
        mon_en = 1;
        @(posedge clk); #1;
        rst_n = 1;
        if (!mst) begin
            repeat (4) @(posedge clk);
            #1;
            fork gen_slave(hl); join_none
        end
        wait (left_cnt >= 1); repeat (5) @(posedge clk);
        push(1);
        wait (left_cnt >= 2); repeat (5) @(posedge clk);
        chk(in_ready == 1, "R8 holder drained at left start", in_ready, 1);
        push(2);
        wait (left_cnt >= 3); repeat (5) @(posedge clk);
        wait (left_cnt >= 4); repeat (5) @(posedge clk);
        chk(underrun == 1, "R9 underrun held in repeat frame", underrun, 1);
        push(3);
        wait (left_cnt >= 5); repeat (5) @(posedge clk);
        chk(underrun == 0, "R9 underrun cleared", underrun, 0);
        wait (left_cnt >= 6);
        if (!mst) begin
            gen_stop = 1;
            wait (gen_done);
        end
        mon_en = 0;
    endtask

    initial begin
        fork
            begin
                for (int f = 0; f < 4; f++) run(1'b1, 2'(f), HB);
                run(1'b0, 2'd0, HB);
                run(1'b0, 2'd1, 24);
                run(1'b0, 2'd2, HB);
            end
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule